// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a configuration-space fabric. It offers two small register windows on a simple host register bus. The address window holds one 32-bit register. That register carries an enable bit, a target bus number, a device/function number and a base register offset. The data window is four bytes wide. Each read or write to it becomes one configuration transaction on the downstream request interface, aimed at the target that the address register names.

Software first writes the address register with a single aligned 32-bit write. It then moves data through the data window with 1, 2 or 4 byte accesses. The bridge forms the register offset and clamps the length so that no access runs past the 256-byte configuration space. It then waits for the downstream response. Targets that are disabled or absent read back as all-ones, and writes to them are dropped.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the address register is zero (enable clear), `hst_busy` is low and `dn_req_valid` is low.
- R2: The address register is written only by an address-window write (`hst_sel_data`=0) with `hst_off`=0 and `hst_len`=4. Any other address-window write leaves it unchanged.
- R3: An address-window read returns the full 32-bit address register for any offset and length, with `hst_rvalid` high in the cycle after the strobe.
- R4: Bit 31 of the address register is the enable. While it is clear, a data-window write issues no request, and a data-window read issues no request and returns 0xFFFFFFFF one cycle after the strobe.
- R5: A downstream request carries the bus number from address bits 23:16 and the device/function from address bits 15:8.
- R6: The request register offset is address bits 7:0 OR-ed with the 2-bit data-window offset `hst_off`, which lands in bits 1:0.
- R7: The request length is the smaller of the requested length (1, 2, or 4 for any other code) and 256 minus the register offset.
- R8: Each enabled data-window access issues exactly one request. `dn_req_valid` and all request fields hold steady until `dn_req_ready`, and valid drops after the handshake. A write request carries `dn_req_write`=1 and `hst_wdata` unchanged.
- R9: A read whose response has `dn_rsp_present`=0 returns 0xFFFFFFFF.
- R10: A read with a present target returns the response bytes below the clamped length in the low byte lanes, with the upper bytes zero. `hst_rvalid` rises only in the cycle after `dn_rsp_valid`.
- R11: `hst_busy` is high from the cycle after an enabled data-window strobe until the response is taken. Host strobes are ignored while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel_data | input | 1 | Window select: 0 address window, 1 data window |
| hst_off | input | 2 | Byte offset inside the selected window |
| hst_len | input | 3 | Access length in bytes (1, 2, 4) |
| hst_wr | input | 1 | Write strobe, one cycle |
| hst_rd | input | 1 | Read strobe, one cycle |
| hst_wdata | input | 32 | Write data |
| hst_rdata | output | 32 | Read data, held until the next read completes |
| hst_rvalid | output | 1 | Read data valid pulse |
| hst_busy | output | 1 | Data-window transaction outstanding |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_write | output | 1 | 1 write, 0 read |
| dn_bus | output | 8 | Target bus number |
| dn_devfn | output | 8 | Target device/function number |
| dn_reg | output | 8 | Configuration register offset |
| dn_len | output | 3 | Clamped byte count |
| dn_wdata | output | 32 | Write data |
| dn_rsp_valid | input | 1 | Response valid |
| dn_rsp_present | input | 1 | A device answered at the target |
| dn_rsp_data | input | 32 | Read data, low-lane aligned |

## Verification
A corrupted address register shows at once on the next address-window read. It also shows in the bus, device/function and offset fields of the very next downstream request. A fault in the offset OR or the length clamp appears only for bases near the top of the space or for non-zero lane offsets. For that reason the bench sweeps every lane and length against bases 0xFC through 0xFF. A sequencer stuck in a wrong state shows within a few cycles as a missing or doubled request, an early `hst_rvalid`, or `hst_busy` never falling, and the bounded waits catch each of these.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

  localparam int DATA_W    = 32;
  localparam int CFG_BYTES = 256;
  localparam int REG_W     = $clog2(CFG_BYTES);
  localparam int LEN_W     = 3;
  localparam int LANES     = DATA_W / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} cfgb_state_e;

  // register offset: stored base OR-ed with the lane offset of the access
  function automatic logic [REG_W-1:0] cfg_offset(input logic [REG_W-1:0] base,
                                                  input logic [1:0] lane);
    return base | {{(REG_W-2){1'b0}}, lane};
  endfunction

  // requested length normalised to 1, 2 or 4
  function automatic logic [LEN_W-1:0] norm_len(input logic [LEN_W-1:0] len);
    return (len == 3'd1 || len == 3'd2) ? len : 3'd4;
  endfunction

  // length limited to the bytes left before the end of config space
  function automatic logic [LEN_W-1:0] clamp_len(input logic [REG_W-1:0] off,
                                                 input logic [LEN_W-1:0] len);
    logic [REG_W:0]     room;
    logic [LEN_W-1:0]   want;
    want = norm_len(len);
    room = (REG_W+1)'(CFG_BYTES) - {1'b0, off};
    return (room < (REG_W+1)'(want)) ? room[LEN_W-1:0] : want;
  endfunction

  // keep the low n byte lanes, zero the rest
  function automatic logic [DATA_W-1:0] keep_low(input logic [DATA_W-1:0] d,
                                                 input logic [LEN_W-1:0] n);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[8*i +: 8] = (LEN_W'(i) < n) ? d[8*i +: 8] : 8'h00;
    return r;
  endfunction

endpackage

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg
  import cfgb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              sel_data_i,
  input  logic              busy_i,
  input  logic [1:0]        off_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] addr_o,
  output logic              en_o,
  output logic [7:0]        bus_o,
  output logic [7:0]        devfn_o,
  output logic [REG_W-1:0]  base_o
);

  logic [DATA_W-1:0] addr_q;
  logic              wr_ok;

  assign wr_ok = wr_i && !sel_data_i && !busy_i && (off_i == 2'd0) && (len_i == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_ok) addr_q <= wdata_i;
  end

  assign addr_o  = addr_q;
  assign en_o    = addr_q[31];
  assign bus_o   = addr_q[23:16];
  assign devfn_o = addr_q[15:8];
  assign base_o  = addr_q[REG_W-1:0];

  AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && !sel_data_i && off_i == 2'd0 && len_i == 3'd4) |=> $stable(addr_q)); // R2

endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq
  import cfgb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_data_i,
  input  logic [1:0]        off_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              en_i,
  input  logic [7:0]        bus_i,
  input  logic [7:0]        devfn_i,
  input  logic [REG_W-1:0]  base_i,
  input  logic              req_ready_i,
  input  logic              rsp_valid_i,
  output logic              req_valid_o,
  output logic              req_write_o,
  output logic [7:0]        bus_o,
  output logic [7:0]        devfn_o,
  output logic [REG_W-1:0]  reg_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              busy_o,
  output logic              ev_addr_rd_o,
  output logic              ev_blank_o,
  output logic              ev_rsp_o
);

  cfgb_state_e       state_q;
  logic              idle, data_acc, launch;
  logic [REG_W-1:0]  tgt_reg;
  logic              write_q;
  logic [7:0]        bus_q, devfn_q;
  logic [REG_W-1:0]  reg_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] wdata_q;

  assign idle     = (state_q == ST_IDLE);
  assign data_acc = idle && sel_data_i && (wr_i || rd_i);
  assign launch   = data_acc && en_i;
  assign tgt_reg  = cfg_offset(base_i, off_i);

  assign ev_addr_rd_o = idle && !sel_data_i && rd_i && !wr_i;
  assign ev_blank_o   = data_acc && !en_i && rd_i && !wr_i;
  assign ev_rsp_o     = (state_q == ST_WAIT) && rsp_valid_i && !write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      bus_q   <= '0;
      devfn_q <= '0;
      reg_q   <= '0;
      len_q   <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch) begin
          state_q <= ST_REQ;
          write_q <= wr_i;
          bus_q   <= bus_i;
          devfn_q <= devfn_i;
          reg_q   <= tgt_reg;
          len_q   <= clamp_len(tgt_reg, len_i);
          wdata_q <= wdata_i;
        end
        ST_REQ:  if (req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == ST_REQ);
  assign req_write_o = write_q;
  assign bus_o       = bus_q;
  assign devfn_o     = devfn_q;
  assign reg_o       = reg_q;
  assign len_o       = len_q;
  assign wdata_o     = wdata_q;
  assign busy_o      = !idle;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> req_valid_o &&
      $stable({write_q, bus_q, devfn_q, reg_q, len_q, wdata_q})); // R8

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=> !req_valid_o); // R8

  AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> en_i); // R4

  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (({1'b0, reg_q} + (REG_W+1)'(len_q)) <= (REG_W+1)'(CFG_BYTES))); // R7

endmodule

// File: rtl/cfgb_rdata.sv
module cfgb_rdata
  import cfgb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_addr_rd_i,
  input  logic              ev_blank_i,
  input  logic              ev_rsp_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic              rsp_present_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= ev_addr_rd_i || ev_blank_i || ev_rsp_i;
      if (ev_addr_rd_i)
        rdata_q <= addr_i;
      else if (ev_blank_i)
        rdata_q <= '1;
      else if (ev_rsp_i)
        rdata_q <= rsp_present_i ? keep_low(rsp_data_i, len_i) : '1;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  AST_BLANK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_blank_i |=> (rvalid_o && rdata_o == '1)); // R4

  AST_ABSENT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rsp_i && !rsp_present_i) |=> (rdata_o == '1)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_addr_rd_i || ev_blank_i || ev_rsp_i) |=> ($stable(rdata_o) && !rvalid_o)); // R10

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_sel_data,
  input  logic [1:0]        hst_off,
  input  logic [LEN_W-1:0]  hst_len,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              hst_rvalid,
  output logic              hst_busy,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic              dn_req_write,
  output logic [7:0]        dn_bus,
  output logic [7:0]        dn_devfn,
  output logic [REG_W-1:0]  dn_reg,
  output logic [LEN_W-1:0]  dn_len,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rsp_valid,
  input  logic              dn_rsp_present,
  input  logic [DATA_W-1:0] dn_rsp_data
);

  logic [DATA_W-1:0] addr_w;
  logic              en_w;
  logic [7:0]        bus_w, devfn_w;
  logic [REG_W-1:0]  base_w;
  logic              busy_w;
  logic              ev_addr_rd, ev_blank, ev_rsp;

  cfgb_addr_reg u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (hst_wr),
    .sel_data_i (hst_sel_data),
    .busy_i     (busy_w),
    .off_i      (hst_off),
    .len_i      (hst_len),
    .wdata_i    (hst_wdata),
    .addr_o     (addr_w),
    .en_o       (en_w),
    .bus_o      (bus_w),
    .devfn_o    (devfn_w),
    .base_o     (base_w)
  );

  cfgb_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_data_i   (hst_sel_data),
    .off_i        (hst_off),
    .len_i        (hst_len),
    .wr_i         (hst_wr),
    .rd_i         (hst_rd),
    .wdata_i      (hst_wdata),
    .en_i         (en_w),
    .bus_i        (bus_w),
    .devfn_i      (devfn_w),
    .base_i       (base_w),
    .req_ready_i  (dn_req_ready),
    .rsp_valid_i  (dn_rsp_valid),
    .req_valid_o  (dn_req_valid),
    .req_write_o  (dn_req_write),
    .bus_o        (dn_bus),
    .devfn_o      (dn_devfn),
    .reg_o        (dn_reg),
    .len_o        (dn_len),
    .wdata_o      (dn_wdata),
    .busy_o       (busy_w),
    .ev_addr_rd_o (ev_addr_rd),
    .ev_blank_o   (ev_blank),
    .ev_rsp_o     (ev_rsp)
  );

  cfgb_rdata u_rdata (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_addr_rd_i  (ev_addr_rd),
    .ev_blank_i    (ev_blank),
    .ev_rsp_i      (ev_rsp),
    .addr_i        (addr_w),
    .rsp_present_i (dn_rsp_present),
    .rsp_data_i    (dn_rsp_data),
    .len_i         (dn_len),
    .rdata_o       (hst_rdata),
    .rvalid_o      (hst_rvalid)
  );

  assign hst_busy = busy_w;

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !dn_req_valid); // R1

  AST_BUSY_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid || $past(dn_req_valid)) |-> hst_busy); // R11

endmodule

// File: tb/sim_cfg_port_bridge.sv
module sim_cfg_port_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_sel_data = 1'b0;
  logic [1:0]  hst_off = '0;
  logic [2:0]  hst_len = '0;
  logic        hst_wr = 1'b0, hst_rd = 1'b0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        hst_rvalid, hst_busy;
  logic        dn_req_valid, dn_req_write;
  logic        dn_req_ready = 1'b0;
  logic [7:0]  dn_bus, dn_devfn, dn_reg;
  logic [2:0]  dn_len;
  logic [31:0] dn_wdata;
  logic        dn_rsp_valid = 1'b0, dn_rsp_present = 1'b0;
  logic [31:0] dn_rsp_data = '0;

  always #2 clk = ~clk;

  cfg_port_bridge u0 (.*);

  int tests = 0, fails = 0;
  int req_cnt = 0, rsp_cnt = 0;
  int hold_cyc = 0;
  bit unstable = 1'b0;
  logic        c_write;
  logic [7:0]  c_bus, c_devfn, c_reg;
  logic [2:0]  c_len;
  logic [31:0] c_wdata;

  function automatic bit dev_here(input logic [7:0] b, input logic [7:0] df);
    return (df[0] == 1'b0) && (b != 8'hEE);
  endfunction
  function automatic logic [31:0] dev_data(input logic [7:0] b, input logic [7:0] df,
                                           input logic [7:0] r);
    return {b ^ 8'h3C, df, r, r ^ 8'hA5};
  endfunction

  task automatic chk(input string req, input bit ok, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // downstream responder
  initial begin
    forever begin
      @(negedge clk);
      if (dn_req_valid) begin
        c_write = dn_req_write; c_bus = dn_bus; c_devfn = dn_devfn;
        c_reg = dn_reg; c_len = dn_len; c_wdata = dn_wdata;
        for (int k = 0; k < hold_cyc; k++) begin
          @(negedge clk);
          if (!dn_req_valid || dn_reg != c_reg || dn_len != c_len || dn_bus != c_bus)
            unstable = 1'b1;
        end
        dn_req_ready = 1'b1;
        @(negedge clk);
        dn_req_ready = 1'b0;
        req_cnt++;
        if (dn_req_valid) unstable = 1'b1;
        repeat (hold_cyc + 1) @(negedge clk);
        dn_rsp_valid   = 1'b1;
        dn_rsp_present = dev_here(c_bus, c_devfn);
        dn_rsp_data    = dev_data(c_bus, c_devfn, c_reg);
        rsp_cnt++;
        @(negedge clk);
        dn_rsp_valid = 1'b0;
      end
    end
  end

  task automatic strobe(input bit sel, input bit wr, input logic [1:0] off,
                        input logic [2:0] len, input logic [31:0] wd);
    @(negedge clk);
    hst_sel_data = sel; hst_wr = wr; hst_rd = !wr;
    hst_off = off; hst_len = len; hst_wdata = wd;
    @(negedge clk);
    hst_wr = 1'b0; hst_rd = 1'b0;
  endtask

  // returns number of negedges until rvalid (1 = cycle after the strobe)
  task automatic wait_rvalid(output int cyc);
    cyc = 1;
    while (!hst_rvalid && cyc < 60) begin @(negedge clk); cyc++; end
  endtask

  task automatic wait_idle;
    for (int k = 0; k < 60 && hst_busy; k++) @(negedge clk);
  endtask

  task automatic addr_read(input logic [1:0] off, input logic [2:0] len,
                           input logic [31:0] exp, input string req);
    int cyc;
    strobe(1'b0, 1'b0, off, len, '0);
    wait_rvalid(cyc);
    chk(req, cyc == 1 && hst_rdata == exp, hst_rdata, exp);
  endtask

  task automatic set_addr(input logic [31:0] v);
    strobe(1'b0, 1'b1, 2'd0, 3'd4, v);
  endtask

  task automatic data_access(input logic [31:0] areg, input bit wr, input logic [1:0] off,
                             input logic [2:0] len, input logic [31:0] wd);
    int r0, q0, cyc;
    logic [7:0]  e_reg;
    logic [2:0]  e_len, nl;
    logic [31:0] e_rd;
    int room;
    r0 = req_cnt; q0 = rsp_cnt;
    e_reg = areg[7:0] | {6'b0, off};                                // R6
    nl    = (len == 3'd1 || len == 3'd2) ? len : 3'd4;
    room  = 256 - int'(e_reg);
    e_len = (room < int'(nl)) ? 3'(room) : nl;                      // R7
    strobe(1'b1, wr, off, len, wd);
    if (!areg[31]) begin
      if (!wr) begin
        wait_rvalid(cyc);
        chk("R4 blank read", cyc == 1 && hst_rdata == 32'hFFFF_FFFF, hst_rdata, 32'hFFFF_FFFF);
      end
      repeat (4) @(negedge clk);
      chk("R4 no request while disabled", req_cnt == r0, 32'(req_cnt - r0), 0);
      return;
    end
    chk("R11 busy after strobe", hst_busy == 1'b1, 32'(hst_busy), 1);
    if (wr) wait_idle();
    else begin
      wait_rvalid(cyc);
      chk("R10 rvalid after response", rsp_cnt == q0 + 1, 32'(rsp_cnt - q0), 1);
      if (dev_here(areg[23:16], areg[15:8])) begin
        e_rd = 32'h0;
        for (int i = 0; i < 4; i++)
          if (i < int'(e_len)) e_rd[8*i +: 8] = dev_data(areg[23:16], areg[15:8], e_reg) >> (8*i);
        chk("R10 present read data", hst_rdata == e_rd, hst_rdata, e_rd);
      end else
        chk("R9 absent read all-ones", hst_rdata == 32'hFFFF_FFFF, hst_rdata, 32'hFFFF_FFFF);
    end
    @(negedge clk);
    chk("R8 one request", req_cnt == r0 + 1 && !unstable, 32'(req_cnt - r0), 1);
    chk("R5 target fields", c_bus == areg[23:16] && c_devfn == areg[15:8],
        {16'h0, c_bus, c_devfn}, {16'h0, areg[23:16], areg[15:8]});
    chk("R6 R7 offset and length", c_reg == e_reg && c_len == e_len,
        {21'h0, c_len, c_reg}, {21'h0, e_len, e_reg});
    chk("R8 direction and data", c_write == wr && (!wr || c_wdata == wd),
        c_wdata, wd);
    chk("R11 idle after completion", !hst_busy, 32'(hst_busy), 0);
  endtask

  bit done = 1'b0;

  initial begin
    logic [31:0] cur;
    logic [7:0] bases [6] = '{8'h00, 8'h10, 8'hFC, 8'hFD, 8'hFE, 8'hFF};
    logic [2:0] lens [3] = '{3'd1, 3'd2, 3'd4};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", !hst_busy && !dn_req_valid, {30'h0, hst_busy, dn_req_valid}, 0);
    addr_read(2'd0, 3'd4, 32'h0, "R1 address reset zero");

    // R2: rejected address writes
    set_addr(32'h8012_3404);
    addr_read(2'd0, 3'd4, 32'h8012_3404, "R2 aligned write taken");
    strobe(1'b0, 1'b1, 2'd1, 3'd4, 32'hDEAD_BEEF);
    addr_read(2'd0, 3'd4, 32'h8012_3404, "R2 offset-1 write ignored");
    strobe(1'b0, 1'b1, 2'd0, 3'd2, 32'hDEAD_BEEF);
    addr_read(2'd0, 3'd4, 32'h8012_3404, "R2 short write ignored");
    strobe(1'b0, 1'b1, 2'd0, 3'd1, 32'hDEAD_BEEF);
    addr_read(2'd0, 3'd4, 32'h8012_3404, "R2 byte write ignored");
    // R3: any offset/length reads full word
    for (int o = 0; o < 4; o++)
      for (int l = 0; l < 3; l++)
        addr_read(2'(o), lens[l], 32'h8012_3404, "R3 full-word read");

    // R4: disabled window
    set_addr(32'h0012_3400);
    data_access(32'h0012_3400, 1'b0, 2'd1, 3'd2, '0);
    data_access(32'h0012_3400, 1'b1, 2'd0, 3'd4, 32'h1111_2222);

    // R5-R10 sweep
    for (int b = 0; b < 6; b++)
      for (int o = 0; o < 4; o++)
        for (int l = 0; l < 3; l++)
          for (int w = 0; w < 2; w++) begin
            cur = {1'b1, 7'h00, 8'(b * 37 + 1), 8'(o + l * 4 + (b & 1)), bases[b]};
            if (o == 3 && l == 2 && w == 0) cur[23:16] = 8'hEE;
            hold_cyc = (b + o + l) % 3;
            set_addr(cur);
            data_access(cur, w[0], 2'(o), lens[l], 32'hA0B0_C0D0 ^ 32'(b * 16 + o));
          end

    // R11: strobes ignored while busy
    cur = 32'h8001_0200;
    set_addr(cur);
    hold_cyc = 2;
    strobe(1'b1, 1'b0, 2'd0, 3'd4, '0);
    strobe(1'b0, 1'b1, 2'd0, 3'd4, 32'h0BAD_0BAD);
    wait_idle();
    repeat (2) @(negedge clk);
    addr_read(2'd0, 3'd4, cur, "R11 address write ignored while busy");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%08h expected=%08h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule